// File: doc/BRIEF.md
# Vector-Chained Descriptor DMA Engine

This engine serves transfer requests from a small set of peripheral sources. Each source owns one slot in a vector table held in memory. The slot holds the address of that source's transfer descriptor. On every request the engine reads the slot and fetches the six-word descriptor from that address. It then copies words from the source address to the destination address, one word per request or the whole remaining count at once. Finally it writes the updated count and addresses back into the descriptor.

When a transfer's count reaches zero, the engine can overwrite the requesting source's vector slot with a chain address taken from the descriptor. The next request from that source then runs from a new descriptor with no other action needed. It can also raise a one-cycle end-of-transfer interrupt that carries a handler address from the descriptor. The vector table, the descriptors and the data all sit in one writable memory space, reached through a simple master port. That port has a fixed one-cycle read latency.

Descriptor layout, at word offsets from its base: 0 mode, 1 count, 2 source address, 3 destination address, 4 chain address, 5 handler address. Mode bits: bit 0 burst, bit 1 chain enable, bit 2 interrupt enable. The slot for source `s` is at address `VEC_BASE + s`.

Top module: `chainDma`

## Requirements
- R1: On a request from source s, the engine reads the word at VEC_BASE + s and uses it as the base of the descriptor, whose words it then reads.
- R2: With mode bit 0 clear, a request whose count is nonzero copies exactly one word, from the source address to the destination address. It then writes back the count minus one and both addresses plus one to descriptor offsets 1, 2 and 3.
- R3: With mode bit 0 set, a single request copies all remaining count words to consecutive addresses and leaves the stored count at zero.
- R4: A request whose stored count is zero makes no memory write and raises no interrupt. The vector slot is left as it was, and the request still completes with a done pulse.
- R5: With mode bit 1 set, when a request brings the count to zero, the chain address (offset 4) is written into vector slot VEC_BASE + s.
- R6: After such a rewrite, the next request from that source is served from the descriptor at the chain address.
- R7: With mode bit 2 set, when a request brings the count to zero, irqPulse is high for one cycle and irqHandler shows offset 5. If mode bit 1 is also set, the vector rewrite happens in that same cycle. With mode bit 1 clear, the slot is not written.
- R8: Requests that are pending together are served lowest source number first.
- R9: A request that arrives while the engine is busy is held and served after the current one.
- R10: Each serviced request gives exactly one single-cycle donePulse with doneSrc naming the source, and busy is high during that cycle.
- R11: After reset, busy, donePulse, irqPulse and memEn are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Per-source request pulses |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Write when high, read when low |
| memAddr | output | ADDR_W | Word address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid the cycle after a read strobe |
| busy | output | 1 | A request is being serviced |
| donePulse | output | 1 | One-cycle end of a serviced request |
| doneSrc | output | SRC_W | Source served, valid with donePulse |
| irqPulse | output | 1 | End-of-transfer interrupt |
| irqHandler | output | DATA_W | Handler address, valid with irqPulse |

## Verification
The bench targets the transfer step that reaches zero. A design that raises the interrupt or rewrites the slot one request early or late shows a wrong count in the descriptor, a wrong slot value, or a missing irq. Zero-count requests are checked for stray writes and interrupts, which would appear if the count test came after the copy. A chained source is requested again to prove that the rewritten slot, and not a cached base, picks the next descriptor. Simultaneous requests and requests made while busy check that the lowest source wins and that no request is lost.

// File: rtl/dmaChainPkg.sv
package dmaChainPkg;
  localparam int DESC_WORDS = 6;
  localparam int MODE_BURST = 0;
  localparam int MODE_CHAIN = 1;
  localparam int MODE_IRQ   = 2;

  typedef enum logic [2:0] {A_VEC, A_DESC, A_WB, A_SRC, A_DST} addrSel_e;
  typedef enum logic [1:0] {W_DATA, W_DESC, W_CHAIN} wdSel_e;

  typedef struct packed {
    logic     memEn;
    logic     memWe;
    addrSel_e addrSel;
    wdSel_e   wdSel;
    logic     ldBase;
    logic     capWord;
    logic     clrIdx;
    logic     incIdx;
    logic     step;
  } strobe_t;
endpackage

// File: rtl/dmaPath.sv
module dmaPath
  import dmaChainPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int SRC_W    = 2,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SRC_W-1:0]  curSrc,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [2:0]        idx,
  output logic              cntZero,
  output logic              cntOne,
  output logic              burst,
  output logic              chainEn,
  output logic              irqEn,
  output logic [DATA_W-1:0] irqHandler
);
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(VEC_BASE);

  logic [ADDR_W-1:0] baseAddr;
  logic [2:0]        modeR;
  logic [DATA_W-1:0] cntR, srcR, dstR, chainR, hndR;
  logic [ADDR_W-1:0] idxExt;

  assign idxExt = {{(ADDR_W-3){1'b0}}, idx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      modeR    <= '0;
      cntR     <= '0;
      srcR     <= '0;
      dstR     <= '0;
      chainR   <= '0;
      hndR     <= '0;
      idx      <= '0;
    end else begin
      if (strb.ldBase) baseAddr <= memRdata[ADDR_W-1:0];
      if (strb.clrIdx) idx <= '0;
      else if (strb.incIdx) idx <= idx + 3'd1;
      if (strb.capWord) begin
        case (idx)
          3'd0: modeR  <= memRdata[2:0];
          3'd1: cntR   <= memRdata;
          3'd2: srcR   <= memRdata;
          3'd3: dstR   <= memRdata;
          3'd4: chainR <= memRdata;
          default: hndR <= memRdata;
        endcase
      end
      if (strb.step) begin
        cntR <= cntR - 1'b1;
        srcR <= srcR + 1'b1;
        dstR <= dstR + 1'b1;
      end
    end
  end

  always_comb begin
    case (strb.addrSel)
      A_VEC:   memAddr = VEC_ADDR + ADDR_W'(curSrc);
      A_DESC:  memAddr = baseAddr + idxExt;
      A_WB:    memAddr = baseAddr + idxExt + ADDR_W'(1);
      A_SRC:   memAddr = srcR[ADDR_W-1:0];
      default: memAddr = dstR[ADDR_W-1:0];
    endcase
  end

  always_comb begin
    case (strb.wdSel)
      W_DATA:  memWdata = memRdata;
      W_CHAIN: memWdata = chainR;
      default: memWdata = (idx == 3'd0) ? cntR : (idx == 3'd1) ? srcR : dstR;
    endcase
  end

  assign cntZero    = (cntR == '0);
  assign cntOne     = (cntR == DATA_W'(1));
  assign burst      = modeR[MODE_BURST];
  assign chainEn    = modeR[MODE_CHAIN];
  assign irqEn      = modeR[MODE_IRQ];
  assign irqHandler = hndR;

  // R2: every copy step takes exactly one off the count and advances both addresses
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (cntR == $past(cntR) - 1'b1) && (srcR == $past(srcR) + 1'b1)
                  && (dstR == $past(dstR) + 1'b1));
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaChainPkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [2:0]         idx,
  input  logic               cntZero,
  input  logic               cntOne,
  input  logic               burst,
  input  logic               chainEn,
  input  logic               irqEn,
  output strobe_t            strb,
  output logic [SRC_W-1:0]   curSrc,
  output logic               busy,
  output logic               donePulse,
  output logic               irqPulse
);
  localparam logic [2:0] LAST_DESC = 3'(DESC_WORDS - 1);

  typedef enum logic [3:0] {S_IDLE, S_VRD, S_VEC, S_RD, S_CAP, S_CHK,
                            S_XRD, S_XWR, S_WB, S_END} state_e;

  state_e             state, nextState;
  logic [NUM_SRC-1:0] pend, clrMask;
  logic [SRC_W-1:0]   pick;
  logic               found, moved;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && !found) begin
        found = 1'b1;
        pick  = SRC_W'(i);
      end
    end
  end

  always_comb begin
    strb      = '0;
    strb.addrSel = A_VEC;
    strb.wdSel   = W_DATA;
    nextState = state;
    clrMask   = '0;
    donePulse = 1'b0;
    irqPulse  = 1'b0;
    case (state)
      S_IDLE: if (found) begin
        clrMask[pick] = 1'b1;
        nextState     = S_VRD;
      end
      S_VRD: begin
        strb.memEn = 1'b1;
        nextState  = S_VEC;
      end
      S_VEC: begin
        strb.ldBase = 1'b1;
        strb.clrIdx = 1'b1;
        nextState   = S_RD;
      end
      S_RD: begin
        strb.memEn   = 1'b1;
        strb.addrSel = A_DESC;
        nextState    = S_CAP;
      end
      S_CAP: begin
        strb.capWord = 1'b1;
        if (idx == LAST_DESC) nextState = S_CHK;
        else begin
          strb.incIdx = 1'b1;
          nextState   = S_RD;
        end
      end
      S_CHK: begin
        strb.clrIdx = 1'b1;
        nextState   = cntZero ? S_END : S_XRD;
      end
      S_XRD: begin
        strb.memEn   = 1'b1;
        strb.addrSel = A_SRC;
        nextState    = S_XWR;
      end
      S_XWR: begin
        strb.memEn   = 1'b1;
        strb.memWe   = 1'b1;
        strb.addrSel = A_DST;
        strb.step    = 1'b1;
        nextState    = (burst && !cntOne) ? S_XRD : S_WB;
      end
      S_WB: begin
        strb.memEn   = 1'b1;
        strb.memWe   = 1'b1;
        strb.addrSel = A_WB;
        strb.wdSel   = W_DESC;
        if (idx == 3'd2) nextState = S_END;
        else strb.incIdx = 1'b1;
      end
      S_END: begin
        donePulse = 1'b1;
        if (moved && cntZero) begin
          if (chainEn) begin
            strb.memEn = 1'b1;
            strb.memWe = 1'b1;
            strb.wdSel = W_CHAIN;
          end
          irqPulse = irqEn;
        end
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      pend   <= '0;
      curSrc <= '0;
      moved  <= 1'b0;
    end else begin
      state <= nextState;
      pend  <= (pend & ~clrMask) | reqIn;
      if (state == S_IDLE && found) curSrc <= pick;
      if (state == S_CHK) moved <= !cntZero;
    end
  end

  assign busy = (state != S_IDLE);

  // R10: done never lasts two cycles
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R11: no memory traffic while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strb.memEn);
  // R4: a zero count goes straight to completion without writes or interrupt
  p_zero_skip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHK && cntZero) |=> (donePulse && !strb.memWe && !irqPulse));
  // R7: with chaining on, the interrupt cycle is also the slot rewrite cycle
  p_irq_with_chain_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && chainEn) |-> (strb.memWe && strb.addrSel == A_VEC));
  // R8: source 0 wins whenever it is pending at arbitration
  p_low_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && pend[0]) |=> (curSrc == '0));
endmodule

// File: rtl/chainDma.sv
module chainDma
  import dmaChainPkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 0,
  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic               memEn,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               busy,
  output logic               donePulse,
  output logic [SRC_W-1:0]   doneSrc,
  output logic               irqPulse,
  output logic [DATA_W-1:0]  irqHandler
);
  strobe_t          strb;
  logic [SRC_W-1:0] curSrc;
  logic [2:0]       idx;
  logic             cntZero, cntOne, burst, chainEn, irqEn;

  dmaCtrl #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .idx(idx),
    .cntZero(cntZero), .cntOne(cntOne), .burst(burst),
    .chainEn(chainEn), .irqEn(irqEn), .strb(strb), .curSrc(curSrc),
    .busy(busy), .donePulse(donePulse), .irqPulse(irqPulse)
  );

  dmaPath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W),
            .VEC_BASE(VEC_BASE)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .curSrc(curSrc),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .idx(idx), .cntZero(cntZero), .cntOne(cntOne), .burst(burst),
    .chainEn(chainEn), .irqEn(irqEn), .irqHandler(irqHandler)
  );

  assign memEn   = strb.memEn;
  assign memWe   = strb.memWe;
  assign doneSrc = curSrc;
endmodule

// File: tb/tb_chainDma.sv
`timescale 1ns/1ps
module tb_chainDma;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  reqIn = '0;
  logic        memEn, memWe, busy, donePulse, irqPulse;
  logic [7:0]  memAddr;
  logic [15:0] memWdata, memRdata, irqHandler;
  logic [1:0]  doneSrc;

  logic [15:0] mem [0:255];
  logic        tbWe = 1'b0;
  logic [7:0]  tbAddr = '0;
  logic [15:0] tbData = '0;

  int checks = 0, fails = 0;
  int doneCnt = 0, writeCnt = 0, irqCnt = 0, doneViol = 0;
  logic [15:0] lastHandler = '0;
  bit   irqVecSame = 0, prevDone = 0;
  logic [1:0] order [0:63];

  always #5 clk = ~clk;

  chainDma dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .donePulse(donePulse), .doneSrc(doneSrc),
    .irqPulse(irqPulse), .irqHandler(irqHandler)
  );

  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memEn && memWe) mem[memAddr] <= memWdata;
    if (memEn && !memWe) memRdata <= mem[memAddr];
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (memEn && memWe) writeCnt++;
      if (irqPulse) begin
        irqCnt++;
        lastHandler = irqHandler;
        irqVecSame  = memEn && memWe && (memAddr < 8'd4);
      end
      if (donePulse) begin
        order[doneCnt[5:0]] = doneSrc;
        doneCnt++;
        if (prevDone || !busy) doneViol++;
      end
      prevDone = donePulse;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic loadDesc(input logic [7:0] b, input logic [15:0] mode,
                          input logic [15:0] cnt, input logic [15:0] s,
                          input logic [15:0] d, input logic [15:0] ch,
                          input logic [15:0] h);
    poke(b, mode); poke(b + 8'd1, cnt); poke(b + 8'd2, s);
    poke(b + 8'd3, d); poke(b + 8'd4, ch); poke(b + 8'd5, h);
  endtask

  task automatic fire(input logic [3:0] mask);
    @(negedge clk); reqIn = mask;
    @(negedge clk); reqIn = '0;
  endtask

  task automatic waitDones(input int n);
    int start = doneCnt;
    int t = 0;
    while (doneCnt < start + n && t < 3000) begin
      @(posedge clk); t++;
    end
    chk(t < 3000, "R10", "done pulses arrived", doneCnt - start, n);
    @(negedge clk);
  endtask

  task automatic testReset();
    bit quiet = 1;
    repeat (5) begin
      @(negedge clk);
      if (busy || donePulse || irqPulse || memEn) quiet = 0;
    end
    chk(quiet, "R11", "idle outputs after reset", quiet, 1);
  endtask

  task automatic testSingle();
    int w0 = writeCnt;
    fire(4'b0001);
    waitDones(1);
    chk(mem[8'hC0] == 16'hA080, "R1", "copied word via slot 0", mem[8'hC0], 16'hA080);
    chk(mem[8'hC1] == 16'h0, "R2", "only one word moved", mem[8'hC1], 0);
    chk(mem[8'h11] == 16'd2, "R2", "count written back", mem[8'h11], 2);
    chk(mem[8'h12] == 16'h81 && mem[8'h13] == 16'hC1, "R2", "addresses advanced",
        mem[8'h13], 16'hC1);
    chk(writeCnt - w0 == 4, "R2", "writes for single step", writeCnt - w0, 4);
    chk(irqCnt == 0, "R7", "no irq before count hits zero", irqCnt, 0);
    fire(4'b0001); waitDones(1);
    fire(4'b0001); waitDones(1);
    chk(mem[8'hC2] == 16'hA082, "R2", "third word", mem[8'hC2], 16'hA082);
    chk(mem[8'h11] == 16'd0, "R2", "count at zero", mem[8'h11], 0);
    chk(irqCnt == 1 && lastHandler == 16'h0B0E, "R7", "irq handler at zero",
        lastHandler, 16'h0B0E);
    chk(!irqVecSame && mem[8'h00] == 16'h10, "R7", "slot untouched without chain",
        mem[8'h00], 16'h10);
  endtask

  task automatic testBurstChain();
    fire(4'b0010);
    waitDones(1);
    chk(mem[8'hD0] == 16'hA090 && mem[8'hD3] == 16'hA093, "R3", "burst copied all",
        mem[8'hD3], 16'hA093);
    chk(mem[8'hD4] == 16'h0, "R3", "burst stops at count", mem[8'hD4], 0);
    chk(mem[8'h21] == 16'h0, "R3", "burst count zero", mem[8'h21], 0);
    chk(mem[8'h01] == 16'h28, "R5", "slot rewritten to chain", mem[8'h01], 16'h28);
    chk(irqCnt == 2 && lastHandler == 16'h1234, "R7", "chain irq handler",
        lastHandler, 16'h1234);
    chk(irqVecSame, "R7", "irq in rewrite cycle", irqVecSame, 1);
    fire(4'b0010);
    waitDones(1);
    chk(mem[8'hE0] == 16'hA0A0, "R6", "served from chained descriptor",
        mem[8'hE0], 16'hA0A0);
    chk(mem[8'h29] == 16'd1, "R6", "chained count decremented", mem[8'h29], 1);
    chk(irqCnt == 2, "R6", "no irq from mode-0 descriptor", irqCnt, 2);
  endtask

  task automatic testZero();
    int w0 = writeCnt, i0 = irqCnt, d0 = doneCnt;
    fire(4'b0100);
    waitDones(1);
    chk(writeCnt == w0, "R4", "zero count writes", writeCnt - w0, 0);
    chk(irqCnt == i0, "R4", "zero count irq", irqCnt - i0, 0);
    chk(mem[8'h02] == 16'h30, "R4", "zero count slot", mem[8'h02], 16'h30);
    chk(doneCnt == d0 + 1, "R4", "zero count done", doneCnt - d0, 1);
  endtask

  task automatic testPriority();
    int d0 = doneCnt;
    fire(4'b1010);
    waitDones(2);
    chk(order[d0[5:0]] == 2'd1, "R8", "first served", order[d0[5:0]], 1);
    chk(order[d0[5:0] + 6'd1] == 2'd3, "R8", "second served",
        order[d0[5:0] + 6'd1], 3);
    chk(mem[8'hE1] == 16'hA0A1 && mem[8'hF8] == 16'hA0B0, "R8", "both copied",
        mem[8'hF8], 16'hA0B0);
  endtask

  task automatic testPending();
    int d0 = doneCnt;
    fire(4'b1000);
    repeat (3) @(negedge clk);
    chk(busy, "R9", "engine busy at second request", busy, 1);
    fire(4'b0100);
    waitDones(2);
    chk(order[d0[5:0]] == 2'd3 && order[d0[5:0] + 6'd1] == 2'd2, "R9",
        "held request served after", order[d0[5:0] + 6'd1], 2);
    chk(mem[8'h39] == 16'd3, "R9", "source 3 count", mem[8'h39], 3);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 256; i++)
      poke(8'(i), (i >= 8'h80 && i < 8'hC0) ? 16'hA000 + 16'(i) : 16'h0);
    poke(8'h00, 16'h10); poke(8'h01, 16'h20);
    poke(8'h02, 16'h30); poke(8'h03, 16'h38);
    loadDesc(8'h10, 16'd4, 16'd3, 16'h80, 16'hC0, 16'h0,  16'h0B0E);
    loadDesc(8'h20, 16'd7, 16'd4, 16'h90, 16'hD0, 16'h28, 16'h1234);
    loadDesc(8'h28, 16'd0, 16'd2, 16'hA0, 16'hE0, 16'h0,  16'h0);
    loadDesc(8'h30, 16'd7, 16'd0, 16'h84, 16'hF0, 16'h10, 16'h7777);
    loadDesc(8'h38, 16'd0, 16'd5, 16'hB0, 16'hF8, 16'h0,  16'h0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testBurstChain();
    testZero();
    testPriority();
    testPending();
    chk(doneViol == 0, "R10", "done width and busy", doneViol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule